// File: doc/BRIEF.md
# Self-Clearing Cross-Domain Soft Reset

This block produces a synchronous soft reset for two clock domains. The request comes from the register-bus side. Software can raise it by writing 1 to a reset bit, or a system-wide soft-reset request input can raise it. The block then sends the request into the protocol clock domain and waits until the protocol domain has applied its reset and acknowledged it. The request and the acknowledge use a level-based four-phase handshake, with a multi-flop synchronizer in each direction.

The reset bit reads back through `busy`. It is 1 for the whole time the reset is pending. It returns to 0 by itself only when the handshake has fully returned to idle, so software polls it to detect completion. The soft reset does not clear `busy`. While the module is in low-power mode with its clocks gated, the block ignores any request, and the bit stays at 0.

Top module: `soft_reset_xdomain`

## Requirements
- R1: When `busy` is 0 and `low_power` is 0, either a bus write with `wr_en`=1 and `wr_data`=1 or a cycle of `sys_req`=1 sets `busy` to 1 on the next `bus_clk` edge.
- R2: While `busy` is 1, further write-1 or `sys_req` requests start no second reset. Each accepted start gives exactly one `bus_srst` pulse and one `proto_srst` pulse.
- R3: `busy` returns to 0 without any software action once the four-phase handshake completes. This takes fewer than 80 `bus_clk` cycles when the protocol clock period is below twice the bus clock period.
- R4: A request made while `low_power` is 1 is ignored. `busy` stays 0 and neither reset output pulses.
- R5: A bus write with `wr_data`=0 has no effect. `busy` stays 0 and no reset is produced.
- R6: `bus_srst` is high for exactly one `bus_clk` cycle. That cycle is the first cycle in which `busy` reads 1, and `bus_srst` does not clear `busy`.
- R7: `proto_srst` is high for exactly one `proto_clk` cycle per accepted reset. It is held for that cycle before the acknowledge is raised.
- R8: After the hard resets, `busy`, `bus_srst` and `proto_srst` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low hard reset, bus domain |
| proto_clk | input | 1 | Protocol-engine clock |
| proto_rst_n | input | 1 | Asynchronous active-low hard reset, protocol domain |
| wr_en | input | 1 | Write strobe for the reset bit |
| wr_data | input | 1 | Value written to the reset bit |
| sys_req | input | 1 | System-wide soft-reset request |
| low_power | input | 1 | Clocks gated for low power; blocks a new start |
| busy | output | 1 | Reset bit readback: 1 while a soft reset is pending |
| bus_srst | output | 1 | One-cycle soft reset pulse, bus domain |
| proto_srst | output | 1 | One-cycle soft reset pulse, protocol domain |

## Verification
The assertions check these on every cycle: the request level is never high without `busy`, `busy` never rises while `low_power` is set, each reset output is a one-cycle pulse, and `busy` falls only after the request and the synchronized acknowledge are both low. Only the bench scenarios can show the rest. These include the exact count of protocol-domain pulses for each request source, that requests during low power or writes of 0 leave no trace, that a repeated request while pending adds no second reset, and that completion arrives within a bounded number of bus cycles.

// File: rtl/soft_reset_xdomain.sv
module soft_reset_xdomain #(
  parameter int SYNC_STAGES = 2
) (
  input  logic bus_clk,
  input  logic bus_rst_n,
  input  logic proto_clk,
  input  logic proto_rst_n,
  input  logic wr_en,
  input  logic wr_data,
  input  logic sys_req,
  input  logic low_power,
  output logic busy,
  output logic bus_srst,
  output logic proto_srst
);

  localparam int LAST = SYNC_STAGES - 1;

  logic                   req_q;
  logic                   ack_q;
  logic [SYNC_STAGES-1:0] req_sync_r;
  logic [SYNC_STAGES-1:0] ack_sync_r;
  logic                   req_seen;
  logic                   ack_seen;
  logic                   start;

  assign req_seen = req_sync_r[LAST];
  assign ack_seen = ack_sync_r[LAST];
  assign start    = ((wr_en && wr_data) || sys_req) && !low_power && !busy;

  // bus domain: the reset bit, the request level, and the local pulse
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      busy     <= 1'b0;
      req_q    <= 1'b0;
      bus_srst <= 1'b0;
    end else begin
      bus_srst <= start;
      if (start) begin
        busy  <= 1'b1;
        req_q <= 1'b1;
      end else if (req_q && ack_seen) begin
        req_q <= 1'b0;
      end else if (busy && !req_q && !ack_seen) begin
        busy  <= 1'b0;
      end
    end
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) ack_sync_r <= '0;
    else            ack_sync_r <= {ack_sync_r[LAST-1:0], ack_q};
  end

  // protocol domain: apply the reset for one cycle, then acknowledge
  always_ff @(posedge proto_clk or negedge proto_rst_n) begin
    if (!proto_rst_n) req_sync_r <= '0;
    else              req_sync_r <= {req_sync_r[LAST-1:0], req_q};
  end

  always_ff @(posedge proto_clk or negedge proto_rst_n) begin
    if (!proto_rst_n) begin
      proto_srst <= 1'b0;
      ack_q      <= 1'b0;
    end else if (!req_seen) begin
      proto_srst <= 1'b0;
      ack_q      <= 1'b0;
    end else if (proto_srst) begin
      proto_srst <= 1'b0;
      ack_q      <= 1'b1;
    end else if (!ack_q) begin
      proto_srst <= 1'b1;
    end
  end

  AST_REQ_WITHIN_BUSY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    req_q |-> busy); // R2
  AST_NO_START_IN_LP: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (low_power && !busy) |=> !busy); // R4
  AST_BUS_PULSE_ONE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    bus_srst |=> !bus_srst); // R6
  AST_BUS_PULSE_AT_START: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(busy) |-> bus_srst); // R6
  AST_CLEAR_AFTER_ACK: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $fell(busy) |-> (!req_q && !ack_seen)); // R3
  AST_PROTO_PULSE_THEN_ACK: assert property (@(posedge proto_clk) disable iff (!proto_rst_n)
    proto_srst |=> (ack_q && !proto_srst)); // R7

  initial begin
    AST_SYNC_DEPTH: assert (SYNC_STAGES >= 2); // R7
  end

endmodule

// File: tb/sim_soft_reset_xdomain.sv
module sim_soft_reset_xdomain;

  logic bus_clk = 0, proto_clk = 0;
  logic bus_rst_n = 0, proto_rst_n = 0;
  logic wr_en = 0, wr_data = 0, sys_req = 0, low_power = 0;
  logic busy, bus_srst, proto_srst;

  int checks = 0, fails = 0;
  int bus_pulses = 0, proto_pulses = 0;

  always #5 bus_clk = ~bus_clk;
  always #7 proto_clk = ~proto_clk;

  always @(negedge bus_clk) if (bus_srst) bus_pulses++;
  always @(negedge proto_clk) if (proto_srst) proto_pulses++;

  soft_reset_xdomain u0 (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
    .proto_clk(proto_clk), .proto_rst_n(proto_rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .sys_req(sys_req), .low_power(low_power),
    .busy(busy), .bus_srst(bus_srst), .proto_srst(proto_srst)
  );

  // {source: 0 write-1, 1 sys_req, 2 write-0, 3 both ; low_power ; start expected}
  localparam logic [3:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b1},
    {2'd1, 1'b0, 1'b1},
    {2'd2, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b0},
    {2'd1, 1'b1, 1'b0},
    {2'd3, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [1:0] src);
    @(negedge bus_clk);
    wr_en   = (src != 2'd1);
    wr_data = (src == 2'd0) || (src == 2'd3);
    sys_req = (src == 2'd1) || (src == 2'd3);
    @(negedge bus_clk);
    wr_en = 0; wr_data = 0; sys_req = 0;
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy && cycles < 80) begin
      @(negedge bus_clk);
      cycles++;
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int b0, p0, cyc;
    repeat (3) @(negedge bus_clk);
    bus_rst_n = 1; proto_rst_n = 1;
    @(negedge bus_clk);
    check("R8 busy", busy, 0);
    check("R8 bus_srst", bus_srst, 0);
    check("R8 proto_srst", proto_srst, 0);

    foreach (VEC[i]) begin
      b0 = bus_pulses; p0 = proto_pulses;
      low_power = VEC[i][1];
      strobe(VEC[i][3:2]);
      check(VEC[i][0] ? "R1 busy set" : "R4/R5 busy stays 0", busy, VEC[i][0]);
      check("R6 bus_srst with first busy cycle", bus_srst, VEC[i][0]);
      @(negedge bus_clk);
      check("R6 bus_srst one cycle", bus_srst, 0);
      check("R6 busy not cleared by own reset", busy, VEC[i][0]);
      wait_idle(cyc);
      check("R3 self-clear", busy, 0);
      repeat (6) @(negedge bus_clk);
      low_power = 0;
      check("R7 proto pulses", proto_pulses - p0, VEC[i][0]);
      check("R2 bus pulses", bus_pulses - b0, VEC[i][0]);
    end

    // R2: repeated requests while pending add nothing
    b0 = bus_pulses; p0 = proto_pulses;
    strobe(2'd0);
    strobe(2'd1);
    check("R2 still pending", busy, 1);
    strobe(2'd3);
    wait_idle(cyc);
    check("R3 clear after repeats", busy, 0);
    check("R3 bound", int'(cyc < 80), 1);
    repeat (6) @(negedge bus_clk);
    check("R2 single proto pulse", proto_pulses - p0, 1);
    check("R2 single bus pulse", bus_pulses - b0, 1);

    // R4: low power raised while a reset is already idle then released; a new request works
    low_power = 1;
    strobe(2'd3);
    check("R4 blocked", busy, 0);
    low_power = 0;
    strobe(2'd1);
    check("R1 after low power", busy, 1);
    wait_idle(cyc);
    check("R3 clear", busy, 0);

    finish_run();
  end

endmodule